// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM of 524,288 locations. It accepts one read or write request at a time and turns it into a timed sequence of active-low chip-select, write-strobe and output-gate signals. It also drives a 19-bit memory address and an 8-bit write-data bus with its own drive enable. Reads return the sampled byte and a one-cycle completion pulse.

Every interval of the sequence is a whole number of system-clock cycles. Each one comes from a nanosecond limit and the clock period, rounded up. With the default 20 ns clock this gives the following counts:

| Interval | Cycles |
|---|---|
| Read window | 4 |
| Write setup | 1 |
| Write pulse | 3 |
| Recovery | 1 |

A protect input freezes the memory side. While it is high, no new access starts, and a write that is offered is answered with an error instead of being performed.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is held and in the first idle cycle after it, the chip-select, write-strobe and output-gate outputs are high (1), the write-data drive enable is low, the completion pulse is low and the ready output is high when protect is low.
- R2: A read holds chip-select and output-gate low with the write strobe high for exactly RD_CYC consecutive cycles. RD_CYC is the largest of the rounded-up read-cycle, address-access and output-gate access counts, 4 at defaults. The memory address equals the requested address throughout.
- R3: A read returns the byte present on the memory data input during the last read-window cycle on the read-data output, with a one-cycle completion pulse and the error flag low, in the cycle after the window closes.
- R4: A write drops chip-select SET_CYC cycles (at least 1) before the write strobe falls. The strobe then stays low for PUL_CYC cycles, the largest of the rounded-up pulse width, data setup, and write-cycle count less SET_CYC (3 at defaults). Chip-select and write strobe rise on the same clock edge. Output-gate stays high for the whole write.
- R5: The write-data drive enable is high exactly in the cycles where the write strobe is low, and the driven data equals the requested write byte.
- R6: The memory address does not change while chip-select is low.
- R7: After chip-select rises, all three strobes stay high for at least REC_CYC cycles (at least 1) before chip-select may fall again.
- R8: Ready is high only while the controller is idle. A request presented while ready is low starts no memory access and produces no completion.
- R9: While protect is high, ready is low and no strobe falls. A write request then yields one completion pulse with the error flag high per cycle it is presented, and memory is left unchanged. A read request yields nothing.
- R10: All cycle counts are ceilings of nanosecond limits divided by the clock period, with a floor of one cycle for setup and recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host presents a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle and able to take a request |
| wr_protect | input | 1 | Blocks new accesses; writes are refused with an error |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Qualifies rsp_done: refused write |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done |
| mem_ce_n | output | 1 | Memory chip-select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq_out | output | 8 | Write data toward the pad |
| mem_dq_oe | output | 1 | Write-data drive enable for the pad |
| mem_dq_in | input | 8 | Read data from the pad |

## Verification
The bench's memory model measures each window length against its own ceiling arithmetic. A controller that truncated instead of rounding up would produce a 3-cycle read or 2-cycle pulse and be flagged. It checks that chip-select and the write strobe rise together and that drive enable tracks the strobe exactly. A design that released data a cycle late, or opened the strobe in the setup cycle, would therefore break contention or setup rules. Requests offered while busy or under protect are counted against the number of memory windows actually seen. A design that queued them or let a protected write through would show extra windows or corrupted read-back. Back-to-back requests and the extreme addresses 0 and 0x7FFFF probe the recovery gap and full address width.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_RECOV
  } ctrl_state_t;

  // Nanoseconds to clock cycles, rounded up.
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  // Same, with a floor of one cycle.
  function automatic int unsigned ns2cyc_min1(int unsigned ns, int unsigned period_ns);
    int unsigned c;
    c = ns2cyc(ns, period_ns);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Remaining cycles of a total after a fixed part, never negative.
  function automatic int unsigned usub(int unsigned a, int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_data <= '0;
    end else if (capture) begin
      out_addr <= in_addr;
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 19,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_RC_NS      = 70,
  parameter int unsigned T_ACC_NS     = 70,
  parameter int unsigned T_OE_NS      = 35,
  parameter int unsigned T_WC_NS      = 70,
  parameter int unsigned T_WP_NS      = 55,
  parameter int unsigned T_DS_NS      = 30,
  parameter int unsigned T_AS_NS      = 0,
  parameter int unsigned T_WR_NS      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              wr_protect,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  // R10: cycle counts derived from nanosecond limits, rounded up
  localparam int unsigned RD_CYC  = umax(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                    umax(ns2cyc(T_ACC_NS, CLK_PERIOD_NS),
                                         ns2cyc(T_OE_NS, CLK_PERIOD_NS)));
  localparam int unsigned SET_CYC = ns2cyc_min1(T_AS_NS, CLK_PERIOD_NS);
  localparam int unsigned PUL_CYC = umax(1, umax(umax(ns2cyc(T_WP_NS, CLK_PERIOD_NS),
                                                      ns2cyc(T_DS_NS, CLK_PERIOD_NS)),
                                    usub(ns2cyc(T_WC_NS, CLK_PERIOD_NS), SET_CYC)));
  localparam int unsigned REC_CYC = ns2cyc_min1(T_WR_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, SET_CYC), umax(PUL_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SET_CYC - 1);
  localparam logic [CNT_W-1:0] PUL_LD = CNT_W'(PUL_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

  ctrl_state_t state, state_nx;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  // Named internal events
  logic accept_evt;     // request taken this cycle
  logic refuse_evt;     // write refused under protect
  logic rd_close_evt;   // read window ends at this edge
  logic wr_close_evt;   // write window ends at this edge
  logic win_open;       // write window is open

  assign req_ready    = (state == ST_IDLE) && !wr_protect;
  assign accept_evt   = req_valid && req_ready;
  assign refuse_evt   = (state == ST_IDLE) && wr_protect && req_valid && req_write;
  assign rd_close_evt = (state == ST_READ)   && tmr_done;
  assign wr_close_evt = (state == ST_WPULSE) && tmr_done;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (accept_evt),
    .in_addr  (req_addr),
    .in_data  (req_wdata),
    .out_addr (mem_addr),
    .out_data (mem_dq_out)
  );

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept_evt) begin
        tmr_load = 1'b1;
        if (req_write) begin state_nx = ST_WSETUP; tmr_val = SET_LD; end
        else           begin state_nx = ST_READ;   tmr_val = RD_LD;  end
      end
      ST_READ:   if (tmr_done) begin state_nx = ST_RECOV;  tmr_load = 1'b1; tmr_val = REC_LD; end
      ST_WSETUP: if (tmr_done) begin state_nx = ST_WPULSE; tmr_load = 1'b1; tmr_val = PUL_LD; end
      ST_WPULSE: if (tmr_done) begin state_nx = ST_RECOV;  tmr_load = 1'b1; tmr_val = REC_LD; end
      ST_RECOV:  if (tmr_done) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state    <= state_nx;
      rsp_done <= rd_close_evt || wr_close_evt || refuse_evt;
      rsp_err  <= refuse_evt;
      if (rd_close_evt) rsp_rdata <= mem_dq_in;
    end
  end

  // Strobes decoded from the registered state
  assign mem_ce_n  = !(state == ST_READ || state == ST_WSETUP || state == ST_WPULSE);
  assign mem_oe_n  = !(state == ST_READ);
  assign mem_we_n  = !(state == ST_WPULSE);
  assign win_open  = !mem_ce_n && !mem_we_n;
  assign mem_dq_oe = (state == ST_WPULSE);

  AST_OE_HIGH_IN_WRITE:  assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);                                             // R4
  AST_WE_NEEDS_CE:       assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);                                            // R4
  AST_SETUP_BEFORE_WE:   assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n));                               // R4
  AST_DRIVE_IN_WINDOW:   assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> win_open);                                             // R5
  AST_ADDR_STABLE:       assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));              // R6
  AST_RECOVERY_GAP:      assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);                                       // R7
  AST_READY_ONLY_IDLE:   assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));                   // R8
  AST_PROTECT_BLOCKS:    assert property (@(posedge clk) disable iff (!rst_n)
    (wr_protect && mem_ce_n) |=> mem_ce_n);                              // R9
  AST_ERR_WITH_DONE:     assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);                                               // R9
endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  // Expected counts, restated from the requirements (20 ns clock)
  localparam int RD_EXP  = 4;   // max(ceil 70/20, ceil 70/20, ceil 35/20)
  localparam int SET_EXP = 1;   // 0 ns rounds to the one-cycle floor
  localparam int PUL_EXP = 3;   // max(ceil 55/20, ceil 30/20, 4-1)
  localparam int REC_EXP = 1;   // ceil 5/20

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, wr_protect = 0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, rsp_err;
  logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [18:0] mem_addr;

  always #10 clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .wr_protect(wr_protect), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic [7:0] rd_byte = 8'h00;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_byte : 8'hEE;

  int windows = 0;
  int rd_len = 0, set_len = 0, pul_len = 0, rec_len = 100;
  logic [18:0] win_addr;
  logic [7:0]  wr_byte;
  logic prev_ce = 1, prev_we = 1, prev_rd = 0;

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (!mem_ce_n && prev_ce) begin
        windows++;
        chk(rec_len >= REC_EXP, "R7", "recovery cycles", rec_len, REC_EXP);
        win_addr = mem_addr;
        rd_len = 0; set_len = 0; pul_len = 0;
      end
      if (!mem_ce_n)
        chk(mem_addr == win_addr, "R6", "address moved", int'(mem_addr), int'(win_addr));
      chk(mem_dq_oe == !mem_we_n, "R5", "drive enable", mem_dq_oe, !mem_we_n);
      if (!mem_we_n) begin
        chk(mem_oe_n, "R4", "oe during write", mem_oe_n, 1);
        chk(mem_dq_out == shadow[int'(mem_addr)], "R5", "write data",
            mem_dq_out, shadow[int'(mem_addr)]);
        wr_byte = mem_dq_out;
        pul_len++;
      end
      if (!mem_ce_n && mem_we_n && mem_oe_n) set_len++;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        rd_len++;
        chk(mem_addr == req_addr_at_accept, "R2", "read address",
            int'(mem_addr), int'(req_addr_at_accept));
      end
      if (!mem_we_n && prev_we)
        chk(set_len == SET_EXP, "R4", "setup cycles", set_len, SET_EXP);
      if (mem_we_n && !prev_we) begin
        chk(pul_len == PUL_EXP, "R4", "pulse cycles", pul_len, PUL_EXP);
        chk(mem_ce_n, "R4", "ce rises with we", mem_ce_n, 1);
        mem[int'(win_addr)] = wr_byte;
      end
      if (prev_rd && mem_ce_n)
        chk(rd_len == RD_EXP, "R2", "read window cycles", rd_len, RD_EXP);
      rec_len = mem_ce_n ? ((!prev_ce) ? 1 : rec_len + 1) : 0;
      prev_rd = !mem_ce_n && !mem_oe_n;
      prev_ce = mem_ce_n;
      prev_we = mem_we_n;
      rd_byte = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit err; bit is_rd; logic [7:0] data; } exp_t;
  exp_t exp_q[$];
  logic [18:0] req_addr_at_accept = '0;

  initial forever begin
    @(negedge clk);
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8", "unexpected completion", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_err == e.err, e.err ? "R9" : "R3", "error flag", rsp_err, e.err);
        if (e.is_rd)
          chk(rsp_rdata == e.data, "R3", "read data", rsp_rdata, e.data);
      end
    end
  end

  task automatic do_req(bit w, logic [18:0] a, logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    req_addr_at_accept = a;
    e.err = 0; e.is_rd = !w;
    e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    if (w) shadow[int'(a)] = d;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int win_before;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!mem_dq_oe && !rsp_done, "R1", "drive/done in reset", {mem_dq_oe, rsp_done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);

    // writes then reads, extreme addresses, back to back
    do_req(1, 19'h00000, 8'hA5);
    do_req(1, 19'h7FFFF, 8'h3C);
    do_req(1, 19'h12345, 8'h00);
    do_req(1, 19'h12346, 8'hFF);
    do_req(0, 19'h00000, 8'h00);
    do_req(0, 19'h7FFFF, 8'h00);
    do_req(0, 19'h12345, 8'h00);
    do_req(0, 19'h12346, 8'h00);
    do_req(0, 19'h55555, 8'h00);   // never written: reads 0
    do_req(1, 19'h12345, 8'h5A);   // overwrite
    do_req(0, 19'h12345, 8'h00);
    drain();
    chk(windows == 11, "R8", "window count", windows, 11);

    // R8: requests while busy are ignored
    do_req(1, 19'h00100, 8'h77);
    req_valid = 1; req_write = 0; req_addr = 19'h00200;
    chk(!req_ready, "R8", "ready while busy", req_ready, 0);
    @(negedge clk);
    chk(!req_ready, "R8", "ready while busy", req_ready, 0);
    req_valid = 0;
    drain();
    chk(windows == 12, "R8", "busy request ignored", windows, 12);

    // R9: protect refuses write, ignores read
    win_before = windows;
    wr_protect = 1;
    @(negedge clk);
    chk(!req_ready, "R9", "ready under protect", req_ready, 0);
    begin
      exp_t e;
      e.err = 1; e.is_rd = 0; e.data = 0;
      exp_q.push_back(e);
    end
    req_valid = 1; req_write = 1; req_addr = 19'h00100; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 19'h00100;
    @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "refusal reported", exp_q.size(), 0);
    chk(windows == win_before, "R9", "no access under protect", windows, win_before);
    wr_protect = 0;
    do_req(0, 19'h00100, 8'h00);   // memory still holds 0x77
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule